// File: doc/BRIEF.md
# Double-Buffered Quad DAC Serial Front End

This block is the digital side of a four-channel digital-to-analog converter. A host shifts a short frame into it over a three-wire serial port: serial data, serial clock and an active-low select. Each frame names one of four channels and carries a code word. When the select is released after a frame of the correct length, the word lands in that channel's input register. A shared, level-sensitive, active-low load strobe then moves all four input registers into the DAC registers that drive the converters, so every output changes in the same cycle.

A clear input, active low, forces every register of every channel to a start value. A strap input picks that value: all zeros, or half scale (only the top code bit set). The power-on reset always gives all zeros. A serial output returns the bit stream one full frame later, so several devices can share one data line in a chain. The block runs on a fast system clock. The serial pins, strobe, clear and strap are treated as signals already synchronous to that clock, and serial clock edges are found by comparing successive samples.

Top module: `quad_dac_frontend`

## Requirements
- R1: While `rst_n_i` is low, every `dac_o` word and `sdo_o` read zero, even with `msb_sel_i` high.
- R2: A frame is `2 + DATA_W` bits (18 by default), sent MSB first and sampled on rising `sclk_i` while `cs_n_i` is low. The first two bits are the channel address (0 = channel 0 in `dac_o[0]` up to 3 = channel 3), and the rest is the code word. On the rising edge of `cs_n_i` the word is written into the addressed input register only, and the other three keep their contents.
- R3: When the number of rising `sclk_i` edges in a select window is not exactly `2 + DATA_W` (for example 17 or 19), no input register changes.
- R4: While `ldac_n_i` is high, `dac_o` does not change, even when input registers are written.
- R5: In every clock cycle that `ldac_n_i` is sampled low, all four DAC registers take their input registers' contents together, one clock later. While the strobe stays low, a newly written word reaches `dac_o` one clock after it is written.
- R6: In a cycle where `clr_n_i` is sampled low, every input register and every DAC register is set one clock later. The value is zero when `msb_sel_i` is 0, and only the top code bit set (0x8000 at 16 bits) when it is 1. The clear overrides a load.
- R7: On each falling `sclk_i` edge while `cs_n_i` is low, `sdo_o` takes the bit that was shifted in `2 + DATA_W` rising edges earlier, carrying over between frames, and it holds at all other times. A chained device therefore reads the previous frame bit by bit on its own rising edges.
- R8: `sclk_i` edges while `cs_n_i` is high have no effect: no bits shift, `sdo_o` holds and no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous power-on reset, active low, clears to zero |
| sclk_i | input | 1 | Serial clock, sampled by `clk_i` |
| cs_n_i | input | 1 | Serial select, active low |
| sdi_i | input | 1 | Serial data in |
| ldac_n_i | input | 1 | Level-sensitive load strobe for all channels, active low |
| clr_n_i | input | 1 | Register clear, active low |
| msb_sel_i | input | 1 | Clear value strap: 0 gives zero, 1 gives half scale |
| sdo_o | output | 1 | Serial data out for daisy-chaining |
| dac_o | output | 4 x DATA_W | DAC register contents, one word per channel |

## Verification
The embedded assertions check on every cycle that:
- a raised strobe keeps the DAC words stable,
- a low strobe copies the prior input words,
- a clear produces the strap-selected value,
- at most one channel is written at a time,
- the shift register and `sdo_o` freeze while they should.

Only the directed scenarios can show the frame format end to end: addressing, MSB-first order, rejection of 17- and 19-bit frames, and the frame-long delay seen on the chained output. The bench also shows that writes stay invisible until a load, and that the power-on state stays zero whatever the strap says.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;

    localparam int unsigned NUM_CH = 4;
    localparam int unsigned ADDR_W = $clog2(NUM_CH);

    typedef logic [ADDR_W-1:0] ch_addr_t;
    typedef logic [NUM_CH-1:0] ch_mask_t;

    // one-hot channel select from the frame address
    function automatic ch_mask_t decode_addr(input ch_addr_t addr);
        ch_mask_t m;
        m = '0;
        m[addr] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/quad_dac_serial.sv
module quad_dac_serial
    import quad_dac_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              wr_en_o,
    output ch_addr_t          wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);

    localparam int unsigned FRAME_W = ADDR_W + DATA_W;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
        logic               sclk_prev;
        logic               cs_n_prev;
        logic               sdo;
    } ser_state_t;

    ser_state_t st_d, st_q;
    logic sclk_rise, sclk_fall, cs_fall, cs_rise;
    logic [CNT_W-1:0] cnt_base;

    always_comb begin
        sclk_rise = sclk_i & ~st_q.sclk_prev & ~cs_n_i;
        sclk_fall = ~sclk_i & st_q.sclk_prev & ~cs_n_i;
        cs_fall   = ~cs_n_i & st_q.cs_n_prev;
        cs_rise   = cs_n_i & ~st_q.cs_n_prev;
        cnt_base  = cs_fall ? '0 : st_q.cnt;

        st_d           = st_q;
        st_d.sclk_prev = sclk_i;
        st_d.cs_n_prev = cs_n_i;
        st_d.cnt       = cnt_base;
        if (sclk_rise) begin
            st_d.shreg = {st_q.shreg[FRAME_W-2:0], sdi_i};
            if (cnt_base != CNT_SAT) begin
                st_d.cnt = cnt_base + 1'b1;
            end
        end
        if (sclk_fall) begin
            st_d.sdo = st_q.shreg[FRAME_W-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q           <= '0;
            st_q.cs_n_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_o     = st_q.sdo;
    assign wr_en_o   = cs_rise && (st_q.cnt == CNT_FULL);
    assign wr_addr_o = st_q.shreg[FRAME_W-1 -: ADDR_W];
    assign wr_data_o = st_q.shreg[DATA_W-1:0];

    // R8: deselected port never shifts
    assert_idle_no_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cs_n_i |=> $stable(st_q.shreg))
        else $error("shift register moved while deselected");

    // R7: serial output only moves on a selected falling edge
    assert_sdo_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cs_n_i || sclk_i || !st_q.sclk_prev) |=> $stable(sdo_o))
        else $error("serial output changed outside a falling edge");

endmodule

// File: rtl/quad_dac_channel.sv
module quad_dac_channel #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              clr_n_i,
    input  logic              msb_sel_i,
    input  logic              ldac_n_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] dac_o
);

    localparam logic [DATA_W-1:0] HALF_SCALE = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] out;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic [DATA_W-1:0] clear_val;

    always_comb begin
        clear_val = msb_sel_i ? HALF_SCALE : '0;
        st_d = st_q;
        if (!clr_n_i) begin
            st_d.hold = clear_val;
            st_d.out  = clear_val;
        end else begin
            if (wr_en_i) begin
                st_d.hold = wr_data_i;
            end
            if (!ldac_n_i) begin
                st_d.out = st_q.hold;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_o = st_q.out;

    assert_hold_no_load_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (clr_n_i && ldac_n_i) |=> $stable(dac_o))
        else $error("DAC word moved without a load");

    assert_load_copies_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (clr_n_i && !ldac_n_i) |=> (dac_o == $past(st_q.hold)))
        else $error("load did not copy the input word");

    assert_clear_half_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!clr_n_i && msb_sel_i) |=> (dac_o == HALF_SCALE && st_q.hold == HALF_SCALE))
        else $error("half-scale clear value wrong");

    assert_clear_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!clr_n_i && !msb_sel_i) |=> (dac_o == '0 && st_q.hold == '0))
        else $error("zero clear value wrong");

endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend
    import quad_dac_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic                           clk_i,
    input  logic                           rst_n_i,
    input  logic                           sclk_i,
    input  logic                           cs_n_i,
    input  logic                           sdi_i,
    input  logic                           ldac_n_i,
    input  logic                           clr_n_i,
    input  logic                           msb_sel_i,
    output logic                           sdo_o,
    output logic [NUM_CH-1:0][DATA_W-1:0]  dac_o
);

    logic              frame_wr;
    ch_addr_t          frame_addr;
    logic [DATA_W-1:0] frame_data;
    ch_mask_t          ch_wr;

    quad_dac_serial #(.DATA_W(DATA_W)) serial_i (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .sclk_i    (sclk_i),
        .cs_n_i    (cs_n_i),
        .sdi_i     (sdi_i),
        .sdo_o     (sdo_o),
        .wr_en_o   (frame_wr),
        .wr_addr_o (frame_addr),
        .wr_data_o (frame_data)
    );

    assign ch_wr = frame_wr ? decode_addr(frame_addr) : '0;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        quad_dac_channel #(.DATA_W(DATA_W)) chan_i (
            .clk_i     (clk_i),
            .rst_n_i   (rst_n_i),
            .clr_n_i   (clr_n_i),
            .msb_sel_i (msb_sel_i),
            .ldac_n_i  (ldac_n_i),
            .wr_en_i   (ch_wr[ch]),
            .wr_data_i (frame_data),
            .dac_o     (dac_o[ch])
        );
    end

    // R2: a completed frame writes one channel at most
    assert_single_write_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot0(ch_wr))
        else $error("more than one channel written");

    // R8: no write while the port was already deselected
    assert_no_write_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cs_n_i |=> (ch_wr == '0 || !$past(cs_n_i)))
        else $error("write issued without a select window");

endmodule

// File: tb/quad_dac_frontend_tb_top.sv
module quad_dac_frontend_tb_top;

    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n, sclk, cs_n, sdi, ldac_n, clr_n, msb_sel;
    logic sdo;
    logic [3:0][DW-1:0] dac;

    int checks = 0;
    int errors = 0;
    logic [31:0] cap;
    logic [DW-1:0] exp_v [4];

    always #4 clk = ~clk;

    quad_dac_frontend #(.DATA_W(DW)) dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
        .ldac_n_i(ldac_n), .clr_n_i(clr_n), .msb_sel_i(msb_sel),
        .sdo_o(sdo), .dac_o(dac)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < 4; c++) check(tag, 32'(dac[c]), 32'(exp_v[c]));
    endtask

    task automatic send_bits(input logic [31:0] word, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi  = word[i];
            sclk = 1'b0;
            repeat (4) @(negedge clk);
            cap  = {cap[30:0], sdo};
            sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
        sclk = 1'b0;
    endtask

    task automatic frame(input logic [31:0] word, input int n);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        send_bits(word, n);
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_ch(input int ch, input logic [DW-1:0] val);
        frame({14'd0, 2'(ch), val}, 18);
    endtask

    task automatic load_pulse();
        ldac_n = 1'b0;
        @(negedge clk);
        ldac_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        msb_sel = 1'b1;
        repeat (3) @(negedge clk);
        for (int c = 0; c < 4; c++) exp_v[c] = '0;
        check_all("R1 reset dac");
        check("R1 reset sdo", 32'(sdo), 32'd0);
        rst_n = 1'b1;
        msb_sel = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_write_each();
        write_ch(0, 16'h1234);
        write_ch(1, 16'habcd);
        write_ch(2, 16'h0001);
        write_ch(3, 16'hffff);
        check_all("R4 no load yet");
        load_pulse();
        exp_v[0] = 16'h1234; exp_v[1] = 16'habcd; exp_v[2] = 16'h0001; exp_v[3] = 16'hffff;
        check_all("R2 addressed words");
    endtask

    task automatic t_simultaneous();
        write_ch(3, 16'h0f0f);
        write_ch(0, 16'h8001);
        write_ch(2, 16'h7ffe);
        check_all("R4 held after writes");
        ldac_n = 1'b0;
        @(negedge clk);
        exp_v[0] = 16'h8001; exp_v[2] = 16'h7ffe; exp_v[3] = 16'h0f0f;
        check_all("R5 same-cycle update");
        write_ch(2, 16'h5a5a);
        exp_v[2] = 16'h5a5a;
        check_all("R5 level pass-through");
        ldac_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_length();
        frame({15'd0, 17'h0_2222}, 17);
        frame({13'd0, 1'b1, 2'd0, 16'h3333}, 19);
        load_pulse();
        check_all("R3 bad lengths dropped");
    endtask

    task automatic t_chain();
        logic [17:0] f1, f2;
        logic held;
        f1 = {2'd1, 16'h3c96};
        f2 = {2'd3, 16'hc3a5};
        frame(32'(f1), 18);
        cap = '0;
        frame(32'(f2), 18);
        check("R7 chained frame", cap, 32'(f1));
        held = sdo;
        sdi = 1'b1;
        send_bits(32'h2a, 6);
        check("R8 sdo held while deselected", 32'(sdo), 32'(held));
        cap = '0;
        frame({14'd0, 2'd1, 16'h3c96}, 18);
        check("R8 shift untouched", cap, 32'(f2));
        load_pulse();
        exp_v[1] = 16'h3c96; exp_v[3] = 16'hc3a5;
        check_all("R2 chain writes");
    endtask

    task automatic t_clear();
        msb_sel = 1'b1;
        clr_n = 1'b0;
        ldac_n = 1'b0;
        @(negedge clk);
        clr_n = 1'b1;
        ldac_n = 1'b1;
        for (int c = 0; c < 4; c++) exp_v[c] = 16'h8000;
        check_all("R6 half-scale clear");
        load_pulse();
        check_all("R6 input regs half-scale");
        write_ch(0, 16'h0777);
        msb_sel = 1'b0;
        clr_n = 1'b0;
        @(negedge clk);
        clr_n = 1'b1;
        for (int c = 0; c < 4; c++) exp_v[c] = '0;
        check_all("R6 zero clear");
        load_pulse();
        check_all("R6 input regs zero");
    endtask

    initial begin
        rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0;
        ldac_n = 1'b1; clr_n = 1'b1; msb_sel = 1'b0; cap = '0;
        @(negedge clk);
        t_reset();
        t_write_each();
        t_simultaneous();
        t_length();
        t_chain();
        t_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule